// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Committed Updates

This block drives four pulse-width modulated pins from a small word-addressed register port. Each channel has its own control, period, phase-offset and duty registers. A common period/duty pair serves any channel that asks for it. Writes land in shadow copies. A single trigger bit in the global word commits every channel's shadow values at once, so all outputs change their configuration on the same clock edge.

Each channel runs a counter through a per-channel state machine with three states: `ST_OFF` (disabled, pin at idle level), `ST_UP` (counting up) and `ST_DOWN` (counting down, used only by the up/down mode). The transitions are named as follows:
- `enable_load`: any state to `ST_UP`, counter loaded with the phase value. It fires on a commit, on a rising enable, or in `ST_OFF` with the enable set.
- `disable`: any state to `ST_OFF` when the enable is clear.
- `wrap`: `ST_UP` to `ST_UP` with the counter set to 0, when the counter reaches the period in the trailing-edge mode.
- `turn_down`: `ST_UP` to `ST_DOWN` at the period in the up/down mode.
- `turn_up`: `ST_DOWN` to `ST_UP` at 0.

A global write is registered first. The commit, or the reload caused by an enable edge, then takes effect at the next rising clock edge.

Top module: `pwm_multi`

## Requirements
- R1: Bits 3:0 of word 0 enable channels 0 to 3. A write to word 0 changes the enables whether or not bit 31 is set.
- R2: Writing word 0 with bit 31 set commits the shadow settings of all channels and the common pair together. Bit 31 reads back as 0, and word 0 reads back the enables in bits 3:0.
- R3: A write to a channel's control, period, phase or duty word, or to the common pair, does not change any output until a commit.
- R4: Word map: 1 is the common period and 2 is the common duty. Channel n uses words 4+4n to 7+4n in this order: control, period, phase, duty. The period, phase and duty words hold 16 bits. Reads return the shadow values, and unmapped words read 0.
- R5: On a commit or a rising enable, the counter of an enabled channel is loaded with that channel's phase value. This sets its offset against the other channels.
- R6: Control bit 4 makes a channel use the common period and duty at commit. The channel keeps its own phase.
- R7: Control bit 3 inverts the channel output.
- R8: Mode 1 (control bits 2:0 = 1) is trailing-edge. The counter goes 0 to the period and wraps to 0, and the output is high while counter < duty. A duty of 0 gives a constant low output and a duty above the period gives a constant high output, both before inversion.
- R9: Mode 2 is up/down. The counter goes 0 up to the period and back down to 0, so one cycle lasts 2 x period clocks. The output is high while counter < duty.
- R10: Mode 0 and codes 3 to 7 hold the output low before inversion.
- R11: A disabled channel drives its committed inversion bit.
- R12: After reset every register is 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pwm_out | output | 4 | PWM outputs, channels 0 to 3 |

## Verification
The assertions check the following on every cycle:
- Committed settings hold still between commits.
- An enabled channel lands on its phase value right after a commit.
- The counter steps by one in `ST_UP` below the period.
- `ST_DOWN` occurs only in the up/down mode.
- A cleared enable always leads to `ST_OFF`.
- A commit follows only a global write carrying the trigger.

Only the bench scenarios can show the following:
- The duty ratio over a full period for each mode, duty extreme and inversion setting.
- The phase offset between two channels.
- The use of the common pair.
- The idle level of a disabled channel.
- That shadow writes stay invisible until a commit.

// File: rtl/pwm_multi_pkg.sv
package pwm_multi_pkg;

    localparam int unsigned CTRL_W    = 5;
    localparam int unsigned BIND_BIT  = 4;
    localparam int unsigned INV_BIT   = 3;

    localparam int unsigned ADDR_GLOBAL = 0;
    localparam int unsigned ADDR_CRANGE = 1;
    localparam int unsigned ADDR_CDUTY  = 2;
    localparam int unsigned CH_BASE     = 4;
    localparam int unsigned CH_STRIDE   = 4;

    localparam int unsigned F_CTRL  = 0;
    localparam int unsigned F_RANGE = 1;
    localparam int unsigned F_PHASE = 2;
    localparam int unsigned F_DUTY  = 3;

    localparam logic [2:0] MODE_OFF    = 3'd0;
    localparam logic [2:0] MODE_TRAIL  = 3'd1;
    localparam logic [2:0] MODE_CENTER = 3'd2;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } chan_state_e;

endpackage

// File: rtl/pwm_multi_regs.sv
module pwm_multi_regs
    import pwm_multi_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned CW  = 16,
    parameter int unsigned AW  = 5,
    parameter int unsigned DW  = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [AW-1:0]                  addr,
    input  logic [DW-1:0]                  wdata,
    output logic [DW-1:0]                  rdata,
    output logic [NCH-1:0]                 en_q,
    output logic [NCH-1:0]                 rise_q,
    output logic                           commit_q,
    output logic [NCH-1:0][CTRL_W-1:0]     sh_ctrl,
    output logic [NCH-1:0][CW-1:0]         sh_range,
    output logic [NCH-1:0][CW-1:0]         sh_phase,
    output logic [NCH-1:0][CW-1:0]         sh_duty,
    output logic [CW-1:0]                  cm_range,
    output logic [CW-1:0]                  cm_duty
);

    localparam int unsigned UPD_BIT = DW - 1;

    logic             glob_wr;
    logic [NCH-1:0]   en_nxt;

    assign glob_wr = wr_en && (addr == AW'(ADDR_GLOBAL));
    assign en_nxt  = glob_wr ? wdata[NCH-1:0] : en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            rise_q   <= '0;
            commit_q <= 1'b0;
        end else begin
            en_q     <= en_nxt;
            rise_q   <= en_nxt & ~en_q;
            commit_q <= glob_wr && wdata[UPD_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cm_range <= '0;
            cm_duty  <= '0;
            sh_ctrl  <= '0;
            sh_range <= '0;
            sh_phase <= '0;
            sh_duty  <= '0;
        end else if (wr_en) begin
            if (addr == AW'(ADDR_CRANGE)) cm_range <= wdata[CW-1:0];
            if (addr == AW'(ADDR_CDUTY))  cm_duty  <= wdata[CW-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (addr == AW'(CH_BASE + CH_STRIDE*i + F_CTRL))
                    sh_ctrl[i]  <= wdata[CTRL_W-1:0];
                if (addr == AW'(CH_BASE + CH_STRIDE*i + F_RANGE))
                    sh_range[i] <= wdata[CW-1:0];
                if (addr == AW'(CH_BASE + CH_STRIDE*i + F_PHASE))
                    sh_phase[i] <= wdata[CW-1:0];
                if (addr == AW'(CH_BASE + CH_STRIDE*i + F_DUTY))
                    sh_duty[i]  <= wdata[CW-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(ADDR_GLOBAL)) rdata[NCH-1:0] = en_q;
        if (addr == AW'(ADDR_CRANGE)) rdata[CW-1:0]  = cm_range;
        if (addr == AW'(ADDR_CDUTY))  rdata[CW-1:0]  = cm_duty;
        for (int i = 0; i < NCH; i++) begin
            if (addr == AW'(CH_BASE + CH_STRIDE*i + F_CTRL))
                rdata[CTRL_W-1:0] = sh_ctrl[i];
            if (addr == AW'(CH_BASE + CH_STRIDE*i + F_RANGE))
                rdata[CW-1:0] = sh_range[i];
            if (addr == AW'(CH_BASE + CH_STRIDE*i + F_PHASE))
                rdata[CW-1:0] = sh_phase[i];
            if (addr == AW'(CH_BASE + CH_STRIDE*i + F_DUTY))
                rdata[CW-1:0] = sh_duty[i];
        end
    end

    // R2
    commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> ($past(wr_en) && ($past(addr) == AW'(ADDR_GLOBAL)) && $past(wdata[UPD_BIT])));

endmodule

// File: rtl/pwm_multi_chan.sv
module pwm_multi_chan
    import pwm_multi_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rise,
    input  logic              commit,
    input  logic [CTRL_W-1:0] sh_ctrl,
    input  logic [CW-1:0]     sh_range,
    input  logic [CW-1:0]     sh_phase,
    input  logic [CW-1:0]     sh_duty,
    input  logic [CW-1:0]     cm_range,
    input  logic [CW-1:0]     cm_duty,
    output logic              pwm_o
);

    chan_state_e state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic [2:0]    act_mode;
    logic          act_inv;
    logic [CW-1:0] act_range, act_duty, act_phase;
    logic [CW-1:0] load_val;
    logic          do_load;
    logic          raw;

    // Committed configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_mode  <= MODE_OFF;
            act_inv   <= 1'b0;
            act_range <= '0;
            act_duty  <= '0;
            act_phase <= '0;
        end else if (commit) begin
            act_mode  <= sh_ctrl[2:0];
            act_inv   <= sh_ctrl[INV_BIT];
            act_range <= sh_ctrl[BIND_BIT] ? cm_range : sh_range;
            act_duty  <= sh_ctrl[BIND_BIT] ? cm_duty  : sh_duty;
            act_phase <= sh_phase;
        end
    end

    assign load_val = commit ? sh_phase : act_phase;
    assign do_load  = commit || rise || (state == ST_OFF);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (!en) begin
            state_nxt = ST_OFF;
            cnt_nxt   = '0;
        end else if (do_load) begin
            state_nxt = ST_UP;
            cnt_nxt   = load_val;
        end else begin
            unique case (state)
                ST_UP: begin
                    if (cnt >= act_range) begin
                        if (act_mode == MODE_CENTER && act_range != '0) begin
                            state_nxt = ST_DOWN;
                            cnt_nxt   = act_range - 1'b1;
                        end else begin
                            state_nxt = ST_UP;
                            cnt_nxt   = '0;
                        end
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                ST_DOWN: begin
                    if (cnt == '0) begin
                        state_nxt = ST_UP;
                        cnt_nxt   = (act_range != '0) ? CW'(1) : '0;
                    end else begin
                        cnt_nxt = cnt - 1'b1;
                    end
                end
                default: begin
                    state_nxt = ST_OFF;
                    cnt_nxt   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        raw = ((act_mode == MODE_TRAIL) || (act_mode == MODE_CENTER)) && (cnt < act_duty);
        unique case (state)
            ST_UP, ST_DOWN: pwm_o = raw ^ act_inv;
            default:        pwm_o = act_inv;
        endcase
    end

    // R3
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_range) && $stable(act_duty) && $stable(act_mode)
                     && $stable(act_inv) && $stable(act_phase)));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && commit) |=> (cnt == $past(sh_phase) && state == ST_UP));

    // R8
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !do_load && state == ST_UP && cnt < act_range) |=> (cnt == $past(cnt) + CW'(1)));

    // R9
    down_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOWN) |-> (act_mode == MODE_CENTER));

    // R11
    off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_OFF));

endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
    import pwm_multi_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned CW  = 16,
    parameter int unsigned AW  = 5,
    parameter int unsigned DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] pwm_out
);

    logic [NCH-1:0]             en_q, rise_q;
    logic                       commit_q;
    logic [NCH-1:0][CTRL_W-1:0] sh_ctrl;
    logic [NCH-1:0][CW-1:0]     sh_range, sh_phase, sh_duty;
    logic [CW-1:0]              cm_range, cm_duty;

    pwm_multi_regs #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .en_q     (en_q),
        .rise_q   (rise_q),
        .commit_q (commit_q),
        .sh_ctrl  (sh_ctrl),
        .sh_range (sh_range),
        .sh_phase (sh_phase),
        .sh_duty  (sh_duty),
        .cm_range (cm_range),
        .cm_duty  (cm_duty)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pwm_multi_chan #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en_q[g]),
            .rise     (rise_q[g]),
            .commit   (commit_q),
            .sh_ctrl  (sh_ctrl[g]),
            .sh_range (sh_range[g]),
            .sh_phase (sh_phase[g]),
            .sh_duty  (sh_duty[g]),
            .cm_range (cm_range),
            .cm_duty  (cm_duty),
            .pwm_o    (pwm_out[g])
        );
    end

endmodule

// File: tb/pwm_multi_test.sv
module pwm_multi_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    typedef struct packed {
        logic [15:0] rng;
        logic [15:0] dty;
        logic [2:0]  md;
        logic        iv;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{16'd9, 16'd3,  3'd1, 1'b0},
        '{16'd9, 16'd0,  3'd1, 1'b0},
        '{16'd9, 16'd10, 3'd1, 1'b0},
        '{16'd9, 16'd4,  3'd1, 1'b1},
        '{16'd6, 16'd3,  3'd2, 1'b0},
        '{16'd6, 16'd7,  3'd2, 1'b0},
        '{16'd6, 16'd2,  3'd2, 1'b1},
        '{16'd5, 16'd3,  3'd0, 1'b0},
        '{16'd5, 16'd3,  3'd6, 1'b0},
        '{16'd5, 16'd3,  3'd7, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pwm_multi uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = 5'(a);
        wdata = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        addr = 5'(a);
        #1;
        d = int'(rdata);
    endtask

    function automatic int caddr(input int ch, input int f);
        return 4 + 4*ch + f;
    endfunction

    task automatic count_high(input int ch, input int n, output int h);
        h = 0;
        for (int k = 0; k < n; k++) begin
            if (pwm_out[ch]) h++;
            @(negedge clk);
        end
    endtask

    function automatic int win(input vec_t v);
        if (v.md == 3'd2) return 2 * int'(v.rng);
        return int'(v.rng) + 1;
    endfunction

    function automatic int exp_high(input vec_t v);
        int r = int'(v.rng);
        int d = int'(v.dty);
        int h;
        if (v.md == 3'd1)      h = (d < r + 1) ? d : r + 1;
        else if (v.md == 3'd2) h = (d == 0) ? 0 : ((d > r) ? 2*r : 2*d - 1);
        else                   h = 0;
        return v.iv ? win(v) - h : h;
    endfunction

    function automatic string vtag(input vec_t v);
        string s;
        if (v.md == 3'd1)      s = "R8";
        else if (v.md == 3'd2) s = "R9";
        else                   s = "R10";
        if (v.iv) s = {s, "/R7"};
        return s;
    endfunction

    initial begin
        int h, d;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 outputs after reset", int'(pwm_out), 0);
        rd(0, d);
        check("R12 global word after reset", d, 0);
        rd(caddr(0, 1), d);
        check("R12 period word after reset", d, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table on channel 0
        for (int i = 0; i < NV; i++) begin
            wr(caddr(0, 0), {28'd0, VECS[i].iv, VECS[i].md});
            wr(caddr(0, 1), int'(VECS[i].rng));
            wr(caddr(0, 2), 0);
            wr(caddr(0, 3), int'(VECS[i].dty));
            wr(0, 32'h8000_0001);
            @(negedge clk);
            count_high(0, win(VECS[i]), h);
            check(vtag(VECS[i]), h, exp_high(VECS[i]));
        end

        // R3: shadow write invisible until commit
        wr(caddr(0, 0), 1);
        wr(caddr(0, 1), 9);
        wr(caddr(0, 3), 3);
        wr(0, 32'h8000_0001);
        @(negedge clk);
        wr(caddr(0, 3), 9);
        count_high(0, 10, h);
        check("R3 duty before commit", h, 3);
        wr(0, 32'h8000_0001);
        @(negedge clk);
        count_high(0, 10, h);
        check("R3 duty after commit", h, 9);

        // R2: readback of global word
        rd(0, d);
        check("R2 trigger reads zero", d, 1);

        // R5: phase offset between ch0 and ch1
        wr(caddr(0, 3), 5);
        wr(caddr(1, 0), 1);
        wr(caddr(1, 1), 9);
        wr(caddr(1, 2), 3);
        wr(caddr(1, 3), 5);
        wr(0, 32'h8000_0003);
        @(negedge clk);
        check("R5 ch1 at phase 3", int'(pwm_out[1]), 1);
        @(negedge clk);
        @(negedge clk);
        check("R5 ch0 at count 2", int'(pwm_out[0]), 1);
        check("R5 ch1 at count 5", int'(pwm_out[1]), 0);

        // R4: readback of shadow word
        wr(caddr(2, 2), 32'h1234);
        rd(caddr(2, 2), d);
        check("R4 phase readback", d, 32'h1234);
        rd(caddr(1, 0), d);
        check("R4 control readback", d, 1);

        // R6: bind to common pair, own phase kept
        wr(1, 4);
        wr(2, 2);
        wr(caddr(2, 0), 32'h11);
        wr(caddr(2, 1), 100);
        wr(caddr(2, 2), 1);
        wr(caddr(2, 3), 50);
        wr(0, 32'h8000_0007);
        @(negedge clk);
        check("R6 bound channel starts at own phase", int'(pwm_out[2]), 1);
        @(negedge clk);
        check("R6 bound channel uses common duty", int'(pwm_out[2]), 0);
        count_high(2, 5, h);
        check("R6 common period ratio", h, 2);

        // R11: disabled channel idles at inversion level
        wr(caddr(3, 0), 32'h09);
        wr(caddr(3, 1), 9);
        wr(caddr(3, 2), 0);
        wr(caddr(3, 3), 3);
        wr(0, 32'h8000_0007);
        @(negedge clk);
        check("R11 disabled inverted idle", int'(pwm_out[3]), 1);

        // R1: enable without commit
        wr(0, 32'h0000_000F);
        @(negedge clk);
        count_high(3, 10, h);
        check("R1 enable starts ch3", h, 7);
        wr(0, 0);
        @(negedge clk);
        check("R1 all disabled idle levels", int'(pwm_out), 8);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule